// File: doc/BRIEF.md
# Interrupt Flag and Wake Controller

This block gathers three interrupt sources for a small 8-bit core: a counter-overflow pulse, an edge on one external pin, and a level change on any of three monitored port pins. It keeps each source's sticky flag, its enable bit and a global enable in one control register. Software reads this register and writes it through a simple port. The block drives an interrupt request to the core. While the core is asleep, it also drives a wake signal.

Every event sets its flag whatever the enables hold. Only a software write of 0 clears a flag, and a hardware event in the same cycle as that write wins. Wake-up needs only a flag and its own enable. The global enable does not gate wake. It decides, through the request line, whether the core vectors after waking or carries on in line. The external pin and the port pins pass through a two-stage synchronizer before edge and change detection. Detection stays disarmed until the synchronizer holds real pin samples after reset.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, `reg_rdata` reads 0x00, and `irq_req` and `wake` are 0.
- R2: A write stores bits 7 (global enable), 5 (timer enable), 4 (external enable), 3 (port-change enable) and flag bits 2..0 from `reg_wdata`. Bit 6 always reads 0.
- R3: A high `tmr_ovf` sets flag bit 2 on that clock edge, whatever the enables hold.
- R4: With `edge_rise_sel`=1, a rising edge on `ext_pin` sets flag bit 1 and a falling edge leaves it clear.
- R5: With `edge_rise_sel`=0, a falling edge on `ext_pin` sets flag bit 1 and a rising edge leaves it clear.
- R6: A level change on any bit of `port_pins` sets flag bit 0, whatever the enables hold.
- R7: A flag keeps its value until a write puts 0 in it. Hardware never clears a flag.
- R8: If an event and a write that clears its flag fall on the same edge, the flag ends up set.
- R9: `irq_req` = bit7 AND ((bit2 AND bit5) OR (bit1 AND bit4) OR (bit0 AND bit3)).
- R10: `wake` = `sleeping` AND ((bit2 AND bit5) OR (bit1 AND bit4) OR (bit0 AND bit3)). The global enable bit 7 plays no part in it.
- R11: A pin change sets its flag on the third rising clock edge after the change. Pin levels present during reset produce no event after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Control register contents |
| edge_rise_sel | input | 1 | External edge select: 1 rising, 0 falling |
| tmr_ovf | input | 1 | One-cycle counter overflow pulse |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| port_pins | input | 3 | Asynchronous monitored port pins |
| sleeping | input | 1 | Core is in sleep |
| irq_req | output | 1 | Interrupt request to the core |
| wake | output | 1 | Wake-up request while sleeping |

## Verification
The assertions check on every cycle that flags fall only after a write, that an overflow pulse always leaves the timer flag set, that a write lands in the enable bits, that a request never rises without the global enable, and that wake never rises outside sleep. The bench's scenarios are needed for the rest. These are edge polarity selection, the three-edge synchronizer latency, change detection on each port pin, event priority over a clearing write, wake without global enable, and the absence of spurious events when pins are high through reset.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  localparam int CTRL_W    = 8;
  localparam int B_PCHG_F  = 0;
  localparam int B_EXT_F   = 1;
  localparam int B_TMR_F   = 2;
  localparam int B_PCHG_E  = 3;
  localparam int B_EXT_E   = 4;
  localparam int B_TMR_E   = 5;
  localparam int B_RSVD    = 6;
  localparam int B_GLB_E   = 7;
  localparam int NUM_SRC   = 3;

  typedef struct packed {
    logic tmr;
    logic ext;
    logic pchg;
  } src_vec_t;
endpackage

// File: rtl/ifc_sync.sv
module ifc_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (gi == 0) begin : g_first
        always_comb stage_d = d_async;
      end else begin : g_rest
        always_comb stage_d = stage_q[gi-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[gi] <= '0;
        else        stage_q[gi] <= stage_d;
      end
    end
  endgenerate

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/ifc_pin_events.sv
module ifc_pin_events #(
  parameter int PORT_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              edge_rise_sel,
  input  logic              ext_pin,
  input  logic [PORT_W-1:0] port_pins,
  output logic              ext_evt,
  output logic              pchg_evt
);
  localparam int ALL_W   = PORT_W + 1;
  localparam int ARM_MAX = SYNC_STAGES + 1;
  localparam int ARM_W   = $clog2(ARM_MAX + 1);

  logic [ALL_W-1:0] smp_now, smp_prev_q, smp_prev_d;
  logic [ARM_W-1:0] arm_q, arm_d;
  logic             arm_en, armed;
  logic             rise, fall;

  ifc_sync #(.WIDTH(ALL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({ext_pin, port_pins}),
    .q_sync  (smp_now)
  );

  // disarmed until every sync stage and the history hold real samples
  always_comb begin
    armed      = (arm_q == ARM_W'(ARM_MAX));
    arm_en     = !armed;
    arm_d      = arm_q + ARM_W'(1);
    smp_prev_d = smp_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      arm_q <= '0;
    else if (arm_en) arm_q <= arm_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp_prev_q <= '0;
    else        smp_prev_q <= smp_prev_d;
  end

  always_comb begin
    rise     = smp_now[PORT_W] & ~smp_prev_q[PORT_W];
    fall     = ~smp_now[PORT_W] & smp_prev_q[PORT_W];
    ext_evt  = armed & (edge_rise_sel ? rise : fall);
    pchg_evt = armed & (|(smp_now[PORT_W-1:0] ^ smp_prev_q[PORT_W-1:0]));
  end
endmodule

// File: rtl/ifc_ctrl_reg.sv
module ifc_ctrl_reg
  import ifc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [CTRL_W-1:0] reg_wdata,
  input  src_vec_t          evt,
  input  logic              sleeping,
  output logic [CTRL_W-1:0] ctrl,
  output logic              irq_req,
  output logic              wake
);
  src_vec_t flag_q, flag_d, en_q, en_d, pend;
  logic     glb_q, glb_d, cfg_en;

  always_comb begin
    cfg_en = reg_wr;
    en_d   = '{tmr: reg_wdata[B_TMR_E], ext: reg_wdata[B_EXT_E], pchg: reg_wdata[B_PCHG_E]};
    glb_d  = reg_wdata[B_GLB_E];
    flag_d = flag_q;
    if (reg_wr)
      flag_d = '{tmr: reg_wdata[B_TMR_F], ext: reg_wdata[B_EXT_F], pchg: reg_wdata[B_PCHG_F]};
    // events override a same-cycle clearing write
    flag_d = flag_d | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      glb_q <= 1'b0;
    end else if (cfg_en) begin
      en_q  <= en_d;
      glb_q <= glb_d;
    end
  end

  always_comb begin
    pend    = flag_q & en_q;
    irq_req = glb_q & (|pend);
    wake    = sleeping & (|pend);
    ctrl              = '0;
    ctrl[B_GLB_E]     = glb_q;
    ctrl[B_RSVD]      = 1'b0;
    ctrl[B_TMR_E]     = en_q.tmr;
    ctrl[B_EXT_E]     = en_q.ext;
    ctrl[B_PCHG_E]    = en_q.pchg;
    ctrl[B_TMR_F]     = flag_q.tmr;
    ctrl[B_EXT_F]     = flag_q.ext;
    ctrl[B_PCHG_F]    = flag_q.pchg;
  end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import ifc_pkg::*;
#(
  parameter int PORT_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [CTRL_W-1:0] reg_rdata,
  input  logic              edge_rise_sel,
  input  logic              tmr_ovf,
  input  logic              ext_pin,
  input  logic [PORT_W-1:0] port_pins,
  input  logic              sleeping,
  output logic              irq_req,
  output logic              wake
);
  logic     ext_evt, pchg_evt;
  src_vec_t evt;

  ifc_pin_events #(.PORT_W(PORT_W), .SYNC_STAGES(SYNC_STAGES)) u_pins (
    .clk           (clk),
    .rst_n         (rst_n),
    .edge_rise_sel (edge_rise_sel),
    .ext_pin       (ext_pin),
    .port_pins     (port_pins),
    .ext_evt       (ext_evt),
    .pchg_evt      (pchg_evt)
  );

  always_comb evt = '{tmr: tmr_ovf, ext: ext_evt, pchg: pchg_evt};

  ifc_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .evt       (evt),
    .sleeping  (sleeping),
    .ctrl      (reg_rdata),
    .irq_req   (irq_req),
    .wake      (wake)
  );
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       tmr_ovf,
  input logic       sleeping,
  input logic       irq_req,
  input logic       wake
);
  a_r7_tmr_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[2] && !reg_wr) |=> reg_rdata[2]);
  a_r7_ext_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[1] && !reg_wr) |=> reg_rdata[1]);
  a_r7_pchg_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[0] && !reg_wr) |=> reg_rdata[0]);
  a_r3_tmr_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> reg_rdata[2]);
  a_r2_enables_written: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (reg_rdata[7] == $past(reg_wdata[7])) && (reg_rdata[5:3] == $past(reg_wdata[5:3])));
  a_r9_irq_needs_global: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> reg_rdata[7]);
  a_r10_wake_only_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    !sleeping |-> !wake);
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .tmr_ovf   (tmr_ovf),
  .sleeping  (sleeping),
  .irq_req   (irq_req),
  .wake      (wake)
);

// File: tb/tb_irq_flag_ctrl.sv
`timescale 1ns/1ps
module tb_irq_flag_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       edge_rise_sel, tmr_ovf, ext_pin, sleeping;
  logic [2:0] port_pins;
  logic       irq_req, wake;
  int         n_chk = 0;
  int         n_err = 0;

  always #2.5 clk = ~clk;

  irq_flag_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .edge_rise_sel(edge_rise_sel), .tmr_ovf(tmr_ovf),
    .ext_pin(ext_pin), .port_pins(port_pins), .sleeping(sleeping),
    .irq_req(irq_req), .wake(wake)
  );

  // {wr, wdata, tmr, slp, exp_rdata, exp_irq, exp_wake}
  localparam int NV = 12;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 8'hFF, 1'b0, 1'b0, 8'hBF, 1'b1, 1'b0}, // R2 R9
    {1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}, // R7 clear
    {1'b0, 8'h00, 1'b1, 1'b0, 8'h04, 1'b0, 1'b0}, // R3 enable off
    {1'b1, 8'h24, 1'b0, 1'b0, 8'h24, 1'b0, 1'b0}, // R9 no global
    {1'b0, 8'h00, 1'b0, 1'b1, 8'h24, 1'b0, 1'b1}, // R10 wake w/o global
    {1'b1, 8'hA4, 1'b0, 1'b0, 8'hA4, 1'b1, 1'b0}, // R9
    {1'b1, 8'h80, 1'b1, 1'b0, 8'h84, 1'b0, 1'b0}, // R8 event wins
    {1'b0, 8'h00, 1'b0, 1'b0, 8'h84, 1'b0, 1'b0}, // R7 hold
    {1'b1, 8'hA0, 1'b0, 1'b0, 8'hA0, 1'b0, 1'b0}, // R7 clear
    {1'b1, 8'h93, 1'b0, 1'b0, 8'h93, 1'b1, 1'b0}, // R9 ext pair
    {1'b1, 8'h91, 1'b0, 1'b0, 8'h91, 1'b0, 1'b0}, // R9 pchg no enable
    {1'b1, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0}  // R10 nothing pending
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    reg_wr = 0; reg_wdata = 0; edge_rise_sel = 1; tmr_ovf = 0;
    ext_pin = 0; port_pins = 0; sleeping = 0;
    do_reset();
    @(negedge clk);
    chk("R1 rdata", reg_rdata, 8'h00);
    chk("R1 irq", {7'd0, irq_req}, 8'h00);
    chk("R1 wake", {7'd0, wake}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      reg_wr = VEC[i][20]; reg_wdata = VEC[i][19:12];
      tmr_ovf = VEC[i][11]; sleeping = VEC[i][10];
      @(posedge clk); #1;
      chk($sformatf("vec%0d rdata", i), reg_rdata, VEC[i][9:2]);
      chk($sformatf("vec%0d irq", i), {7'd0, irq_req}, {7'd0, VEC[i][1]});
      chk($sformatf("vec%0d wake", i), {7'd0, wake}, {7'd0, VEC[i][0]});
    end
    @(negedge clk); reg_wr = 0; tmr_ovf = 0; sleeping = 0;

    // R4 / R11: rising edge with rising select, latency of three edges
    edge_rise_sel = 1;
    @(negedge clk); ext_pin = 1;
    repeat (2) @(posedge clk); #1;
    chk("R11 not yet", reg_rdata, 8'h00);
    @(posedge clk); #1;
    chk("R4 R11 rise sets", reg_rdata, 8'h02);
    wr(8'h00);
    @(negedge clk); ext_pin = 0;
    repeat (5) @(negedge clk);
    chk("R4 fall ignored", reg_rdata, 8'h00);

    // R5: falling select
    edge_rise_sel = 0;
    @(negedge clk); ext_pin = 1;
    repeat (5) @(negedge clk);
    chk("R5 rise ignored", reg_rdata, 8'h00);
    ext_pin = 0;
    repeat (5) @(negedge clk);
    chk("R5 fall sets", reg_rdata, 8'h02);
    wr(8'h00);

    // R6: each port pin, enables off
    for (int p = 0; p < 3; p++) begin
      @(negedge clk); port_pins[p] = ~port_pins[p];
      repeat (5) @(negedge clk);
      chk($sformatf("R6 pin%0d", p), reg_rdata, 8'h01);
      wr(8'h00);
      repeat (2) @(negedge clk);
      chk($sformatf("R7 pin%0d cleared", p), reg_rdata, 8'h00);
    end

    // R11: pins high across reset make no event
    edge_rise_sel = 1; ext_pin = 1; port_pins = 3'b111;
    do_reset();
    repeat (8) @(negedge clk);
    chk("R11 no reset event", reg_rdata, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule